// File: doc/BRIEF.md
# Pushbutton Chord Test Sequencer

This block turns three active-low mechanical pushbuttons into the control actions of a multi-lane serial loopback test. Each button is brought into the clock domain by a two-flop synchroniser and filtered by a debounce counter. A press lasting a single clock is therefore not a press. A gesture opens when the first button is seen pressed and closes when every button is released again. The block acts only at that close, on the full set of buttons that were held at any time during the gesture. A two-button chord therefore never also fires the single-button actions of its members.

A lone button turns on one of three sticky test enables: comma detection, lane bonding or pseudo-random pattern transmission. A two-button chord produces a one-cycle command: inject one error into the transmit stream, or select one of two LED display modes. The block also registers the lock, sync and done indications reported by the lanes onto a four-bit status vector. Bit 3 of that vector holds an error flag that latches on the first reported mismatch. An active-low reset returns everything to idle.

Top module: `chord_seq_top`

## Requirements
- R1: A gesture in which only button 0 was pressed sets `comma_det_en` when it closes. The output stays at 1 until reset.
- R2: A gesture in which only button 1 was pressed sets `chan_bond_en`, which is sticky until reset.
- R3: A gesture in which only button 2 was pressed sets `prbs_tx_en`, which is sticky until reset.
- R4: A gesture whose pressed set is exactly {1,2} produces one `err_inject` pulse, exactly one clock long. It leaves the three enables unchanged.
- R5: A pressed set of exactly {0,1} produces one one-clock `led_mode_green` pulse, and {0,2} produces one one-clock `led_mode_red` pulse. The buttons may be pressed and released in any order within the gesture.
- R6: No action fires while any debounced button is still held. Actions fire only after all buttons are released.
- R7: A button level that holds for fewer than `STABLE_CYCLES` clocks after synchronisation is ignored.
- R8: A gesture in which all three buttons were pressed produces no action.
- R9: `status_led[0]`, `status_led[1]` and `status_led[2]` show lane PLL lock, pattern sync and test done respectively, each delayed by one clock.
- R10: `status_led[3]` becomes 1 on the clock after `lane_err_i` is first seen high. It stays at 1 until reset.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset to idle |
| btn_n | input | 3 | Raw pushbuttons, low when pressed |
| pll_locked_i | input | 1 | Lane PLLs locked |
| pat_sync_i | input | 1 | Lanes aligned, bonded and first pattern data received |
| test_done_i | input | 1 | Lane test complete |
| lane_err_i | input | 1 | Pattern mismatch reported by a lane |
| comma_det_en | output | 1 | Sticky comma detection enable |
| chan_bond_en | output | 1 | Sticky lane bonding enable |
| prbs_tx_en | output | 1 | Sticky pattern transmission enable |
| err_inject | output | 1 | One-clock error injection command |
| led_mode_green | output | 1 | One-clock select of moving-orange-on-green LED mode |
| led_mode_red | output | 1 | One-clock select of moving-orange-on-red LED mode |
| status_led | output | 4 | {error latched, done, sync, lock} |

## Verification
The bench targets staggered chords, in which one button goes down before the other and comes up before it. A decoder that acts on the first release, or that classifies the gesture by the buttons held at the moment of release, would fire a single-button enable there instead of the mode pulse. It holds a button and checks that its enable stays low until release. An edge-triggered decoder would set the enable early. It sends short glitches and the three-button chord, where a weak filter or an incomplete chord map would emit an action. Each pulse must be consumed by exactly one expected entry, so a pulse that lasts two clocks or fires twice for one gesture shows up as an unexpected command.

// File: rtl/chord_seq_pkg.sv
package chord_seq_pkg;

    localparam int NUM_BTN = 3;

    typedef enum logic [0:0] {
        G_IDLE   = 1'b0,
        G_ACTIVE = 1'b1
    } gest_state_e;

    typedef struct packed {
        gest_state_e        state;
        logic [NUM_BTN-1:0] seen;
        logic               comma_en;
        logic               bond_en;
        logic               prbs_en;
        logic               inject;
        logic               mode_grn;
        logic               mode_red;
    } gest_regs_t;

    typedef struct packed {
        logic lock;
        logic sync;
        logic done;
        logic err;
    } stat_regs_t;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int STABLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_pressed,
    output logic pressed
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          level;
        logic [CW-1:0] cnt;
    } db_regs_t;

    db_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.meta = raw_pressed;
        r_d.sync = r_q.meta;
        if (r_q.sync == r_q.level) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(STABLE_CYCLES - 1)) begin
            r_d.cnt   = '0;
            r_d.level = r_q.sync;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pressed = r_q.level;

    // R7: the filtered level may only move to the value the synchroniser holds
    a_r7_level_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.level) |-> (r_q.level == $past(r_q.sync)));

endmodule

// File: rtl/gesture_decoder.sv
module gesture_decoder
    import chord_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] pressed,
    output logic               comma_en,
    output logic               bond_en,
    output logic               prbs_en,
    output logic               inject,
    output logic               mode_grn,
    output logic               mode_red
);
    gest_regs_t g_q, g_d;

    always_comb begin
        g_d          = g_q;
        g_d.inject   = 1'b0;
        g_d.mode_grn = 1'b0;
        g_d.mode_red = 1'b0;
        unique case (g_q.state)
            G_IDLE: begin
                if (|pressed) begin
                    g_d.state = G_ACTIVE;
                    g_d.seen  = pressed;
                end
            end
            G_ACTIVE: begin
                g_d.seen = g_q.seen | pressed;
                if (pressed == '0) begin
                    g_d.state = G_IDLE;
                    g_d.seen  = '0;
                    unique case (g_q.seen)
                        3'b001:  g_d.comma_en = 1'b1;
                        3'b010:  g_d.bond_en  = 1'b1;
                        3'b100:  g_d.prbs_en  = 1'b1;
                        3'b110:  g_d.inject   = 1'b1;
                        3'b011:  g_d.mode_grn = 1'b1;
                        3'b101:  g_d.mode_red = 1'b1;
                        default: ;
                    endcase
                end
            end
            default: g_d.state = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign comma_en = g_q.comma_en;
    assign bond_en  = g_q.bond_en;
    assign prbs_en  = g_q.prbs_en;
    assign inject   = g_q.inject;
    assign mode_grn = g_q.mode_grn;
    assign mode_red = g_q.mode_red;

    // R5: at most one chord command per clock
    a_r5_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_q.inject, g_q.mode_grn, g_q.mode_red}));
    // R6: a held button blocks every action on the next clock
    a_r6_no_fire_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|pressed) |=> !(g_q.inject | g_q.mode_grn | g_q.mode_red));
    // R4: the inject command lasts one clock
    a_r4_inject_single: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.inject |=> !g_q.inject);
    // R1: comma enable is sticky
    a_r1_comma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.comma_en |=> g_q.comma_en);
    // R2: bond enable is sticky
    a_r2_bond_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.bond_en |=> g_q.bond_en);
    // R3: pattern enable is sticky
    a_r3_prbs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.prbs_en |=> g_q.prbs_en);

endmodule

// File: rtl/status_block.sv
module status_block
    import chord_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_i,
    input  logic       sync_i,
    input  logic       done_i,
    input  logic       err_i,
    output logic [3:0] status
);
    stat_regs_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.lock = lock_i;
        s_d.sync = sync_i;
        s_d.done = done_i;
        s_d.err  = s_q.err | err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status = {s_q.err, s_q.done, s_q.sync, s_q.lock};

    // R9: lock shows one clock late
    a_r9_lock_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[0] == $past(lock_i)));
    // R10: error flag never drops outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |=> status[3]);
    // R10: a reported error is captured on the next clock
    a_r10_err_capture: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> status[3]);

endmodule

// File: rtl/chord_seq_top.sv
module chord_seq_top
    import chord_seq_pkg::*;
#(
    parameter int STABLE_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] btn_n,
    input  logic       pll_locked_i,
    input  logic       pat_sync_i,
    input  logic       test_done_i,
    input  logic       lane_err_i,
    output logic       comma_det_en,
    output logic       chan_bond_en,
    output logic       prbs_tx_en,
    output logic       err_inject,
    output logic       led_mode_green,
    output logic       led_mode_red,
    output logic [3:0] status_led
);
    logic [NUM_BTN-1:0] pressed;

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        btn_debounce #(
            .STABLE_CYCLES(STABLE_CYCLES)
        ) u_db (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_pressed(~btn_n[b]),
            .pressed    (pressed[b])
        );
    end

    gesture_decoder u_gest (
        .clk     (clk),
        .rst_n   (rst_n),
        .pressed (pressed),
        .comma_en(comma_det_en),
        .bond_en (chan_bond_en),
        .prbs_en (prbs_tx_en),
        .inject  (err_inject),
        .mode_grn(led_mode_green),
        .mode_red(led_mode_red)
    );

    status_block u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .lock_i(pll_locked_i),
        .sync_i(pat_sync_i),
        .done_i(test_done_i),
        .err_i (lane_err_i),
        .status(status_led)
    );

endmodule

// File: tb/chord_seq_top_tb_top.sv
module chord_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STABLE     = 8;
    localparam int HOLD       = 30;

    localparam int K_INJ = 1;
    localparam int K_GRN = 2;
    localparam int K_RED = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] btn_n = 3'b111;
    logic       lock_i = 1'b0, sync_i = 1'b0, done_i = 1'b0, err_i = 1'b0;
    logic       comma_det_en, chan_bond_en, prbs_tx_en;
    logic       err_inject, led_mode_green, led_mode_red;
    logic [3:0] status_led;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chord_seq_top #(.STABLE_CYCLES(STABLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .pll_locked_i(lock_i), .pat_sync_i(sync_i), .test_done_i(done_i),
        .lane_err_i(err_i),
        .comma_det_en(comma_det_en), .chan_bond_en(chan_bond_en),
        .prbs_tx_en(prbs_tx_en), .err_inject(err_inject),
        .led_mode_green(led_mode_green), .led_mode_red(led_mode_red),
        .status_led(status_led)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every command pulse consumes one expected entry
    always @(negedge clk) begin
        if (rst_n) begin
            int kind;
            kind = 0;
            if (err_inject)     kind = K_INJ;
            if (led_mode_green) kind = K_GRN;
            if (led_mode_red)   kind = K_RED;
            if (kind != 0) begin
                if (exp_q.size() == 0) check("R4/R5/R8 unexpected command", kind, 0);
                else check("R4/R5 command kind", kind, exp_q.pop_front());
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // staggered gesture: press a, then b, release a, then b
    task automatic gesture2(logic [2:0] a, logic [2:0] b, int kind);
        if (kind != 0) exp_q.push_back(kind);
        btn_n = ~a;          wait_cyc(HOLD);
        btn_n = ~(a | b);    wait_cyc(HOLD);
        btn_n = ~b;          wait_cyc(HOLD);
        btn_n = 3'b111;      wait_cyc(HOLD);
    endtask

    task automatic drain(string req);
        check(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        wait_cyc(3);
        check("R11 reset comma", comma_det_en, 0);
        check("R11 reset status", status_led, 0);
        check("R11 reset pulses", {err_inject, led_mode_green, led_mode_red}, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R7: glitches shorter than the stable time
        btn_n = 3'b110; wait_cyc(3); btn_n = 3'b111; wait_cyc(HOLD);
        btn_n = 3'b001; wait_cyc(STABLE - 3); btn_n = 3'b111; wait_cyc(HOLD);
        check("R7 glitch enables", {comma_det_en, chan_bond_en, prbs_tx_en}, 0);

        // R4: chord 1+2
        gesture2(3'b010, 3'b100, K_INJ);
        drain("R4 inject seen");
        check("R4 enables untouched", {comma_det_en, chan_bond_en, prbs_tx_en}, 0);

        // R5: staggered chords, both orders
        gesture2(3'b001, 3'b010, K_GRN);
        drain("R5 green seen");
        gesture2(3'b100, 3'b001, K_RED);
        drain("R5 red seen");
        check("R5 enables untouched", {comma_det_en, chan_bond_en, prbs_tx_en}, 0);

        // R8: all three buttons
        btn_n = 3'b110; wait_cyc(HOLD);
        btn_n = 3'b000; wait_cyc(HOLD);
        btn_n = 3'b111; wait_cyc(HOLD);
        check("R8 triple enables", {comma_det_en, chan_bond_en, prbs_tx_en}, 0);

        // R6 + R1: held button does nothing until release
        btn_n = 3'b110; wait_cyc(HOLD);
        check("R6 held no comma", comma_det_en, 0);
        btn_n = 3'b111; wait_cyc(HOLD);
        check("R1 comma set", comma_det_en, 1);

        btn_n = 3'b101; wait_cyc(HOLD); btn_n = 3'b111; wait_cyc(HOLD);
        check("R2 bond set", chan_bond_en, 1);
        btn_n = 3'b011; wait_cyc(HOLD); btn_n = 3'b111; wait_cyc(HOLD);
        check("R3 prbs set", prbs_tx_en, 1);
        check("R1 comma still set", comma_det_en, 1);

        // R9: status follows lanes one clock late
        lock_i = 1'b1; sync_i = 1'b0; done_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 status low bits", status_led[2:0], 3'b101);
        lock_i = 1'b0; sync_i = 1'b1; done_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 status low bits 2", status_led[2:0], 3'b010);

        // R10: error latch
        check("R10 no err yet", status_led[3], 0);
        err_i = 1'b1; @(posedge clk); @(negedge clk);
        check("R10 err captured", status_led[3], 1);
        err_i = 1'b0; wait_cyc(10);
        check("R10 err held", status_led[3], 1);

        // R11: reset clears everything
        rst_n = 1'b0; wait_cyc(2);
        check("R11 reset enables", {comma_det_en, chan_bond_en, prbs_tx_en}, 0);
        check("R11 reset err", status_led[3], 0);
        rst_n = 1'b1; wait_cyc(2);
        check("R10 err stays clear", status_led[3], 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule